// File: doc/BRIEF.md
# BCD Time-of-Day and Calendar Counter

This block keeps wall-clock time and the calendar date in packed BCD. It advances by one second on each cycle in which the one-second strobe is high. Seconds, minutes, hours, day of month, month, two-digit year and day of week are held in separate registers. All carries settle within that one cycle, so a strobe at 23:59:59 on the last day of a year moves every field at once. Month lengths follow the calendar. February gets a 29th day in every year whose value is a multiple of four. The year field spans 00 to 99 and then wraps.

Software sets the time through a write port that carries a field address and a data byte. All seven fields are always visible on the read outputs. A format input chooses between a 24-hour count and a 12-hour count that carries an afternoon flag in the hours byte. A power-loss input stops the count. The count also starts out stopped after reset. It stays stopped until software writes any field, which reflects that the stored time cannot be trusted after a total loss of supply.

Top module: `bcd_calendar_counter`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hours 00, date 01, month 01, year 00 and weekday 0, and strobes have no effect until the first field write.
- R2: A write with address 0..6 loads seconds, minutes, hours, date, month, year or weekday. The byte is masked to 7F, 7F, 3F, 3F, 1F, FF and 07 respectively. Address 7 changes no field.
- R3: A write takes priority over a strobe in the same cycle: that strobe is discarded and no field counts.
- R4: Seconds and minutes count 00..59 in BCD. A strobe at 59 seconds clears seconds and advances minutes in the same cycle, and 59:59 also advances the hour.
- R5: With the format input low, hours count 00..23 and roll to 00 with a carry into the date.
- R6: With the format input high, hours bits 4:0 count 12, 01 .. 11 and bit 5 is the afternoon flag. The flag toggles on the 11 to 12 step, and the date advances on the step from 11 with the flag set.
- R7: Months 04, 06, 09 and 11 roll from day 30 to day 01 of the next month. Months 01, 03, 05, 07, 08, 10 and 12 roll after day 31.
- R8: February rolls after day 29 when the binary year value is a multiple of four (year 00 included) and after day 28 otherwise.
- R9: After day 31 of month 12 the month becomes 01 and the year advances, with 99 wrapping to 00.
- R10: The weekday counts 0..6, wraps to 0, and advances exactly when the date advances.
- R11: A high power-loss input stops the count from the next cycle until a field write. When both occur in the same cycle, the count stays stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-second strobe, one step per high cycle |
| fmt_12h | input | 1 | 1 selects 12-hour count with afternoon flag, 0 selects 24-hour |
| pwr_lost | input | 1 | Supply loss indication, stops the count |
| wr_en | input | 1 | Field write strobe |
| wr_addr | input | 3 | Field address: 0 sec, 1 min, 2 hour, 3 date, 4 month, 5 year, 6 weekday |
| wr_data | input | 8 | BCD value to load |
| rd_sec | output | 8 | Seconds, BCD |
| rd_min | output | 8 | Minutes, BCD |
| rd_hour | output | 8 | Hours, BCD, bit 5 afternoon flag in 12-hour count |
| rd_date | output | 8 | Day of month, BCD |
| rd_month | output | 8 | Month, BCD |
| rd_year | output | 8 | Year 00..99, BCD |
| rd_dow | output | 8 | Weekday 0..6 |

## Verification
The hardest states to reach are the full-width carries: a single strobe that must ripple from seconds through hours into the date, month and year, and the leap-year test that converts the BCD year to binary. Reaching them by counting would take millions of strobes. The bench instead writes every field to the second before each boundary and then applies one strobe. It picks years such as 00, 12, 10 and 23 so that both the tens digit and the units digit of the year affect the multiple-of-four test.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

    localparam int FIELD_W = 8;
    localparam int ADDR_W  = 3;

    typedef enum logic [ADDR_W-1:0] {
        F_SEC   = 3'd0,
        F_MIN   = 3'd1,
        F_HOUR  = 3'd2,
        F_DATE  = 3'd3,
        F_MONTH = 3'd4,
        F_YEAR  = 3'd5,
        F_DOW   = 3'd6,
        F_NONE  = 3'd7
    } field_e;

    localparam logic [FIELD_W-1:0] MASK_SEC   = 8'h7F;
    localparam logic [FIELD_W-1:0] MASK_MIN   = 8'h7F;
    localparam logic [FIELD_W-1:0] MASK_HOUR  = 8'h3F;
    localparam logic [FIELD_W-1:0] MASK_DATE  = 8'h3F;
    localparam logic [FIELD_W-1:0] MASK_MONTH = 8'h1F;
    localparam logic [FIELD_W-1:0] MASK_YEAR  = 8'hFF;
    localparam logic [FIELD_W-1:0] MASK_DOW   = 8'h07;

    localparam int PM_BIT = 5;

    typedef struct packed {
        logic                load;
        logic [FIELD_W-1:0]  value;
    } field_wr_t;

    // Increment a two-digit BCD byte (no wrap handling at 99).
    function automatic logic [FIELD_W-1:0] bcd_next(input logic [FIELD_W-1:0] v);
        logic [FIELD_W-1:0] r;
        if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
        else                r = {v[7:4], v[3:0] + 4'd1};
        return r;
    endfunction

    function automatic logic [FIELD_W-1:0] bcd_to_bin(input logic [FIELD_W-1:0] v);
        logic [FIELD_W-1:0] t;
        t = {4'h0, v[7:4]};
        return (t << 3) + (t << 1) + {4'h0, v[3:0]};
    endfunction

    function automatic logic is_leap(input logic [FIELD_W-1:0] year_bcd);
        logic [FIELD_W-1:0] b;
        b = bcd_to_bin(year_bcd);
        return (b[1:0] == 2'b00);
    endfunction

    function automatic logic [FIELD_W-1:0] last_day(input logic [FIELD_W-1:0] month_bcd,
                                                    input logic [FIELD_W-1:0] year_bcd);
        logic [FIELD_W-1:0] d;
        case (month_bcd)
            8'h02:                      d = is_leap(year_bcd) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
            default:                    d = 8'h31;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/cal_hold_ctl.sv
module cal_hold_ctl (
    input  logic clk,
    input  logic rst,
    input  logic sec_tick,
    input  logic pwr_lost,
    input  logic any_write,
    output logic frozen,
    output logic advance
);
    logic frozen_q;

    always_ff @(posedge clk) begin
        if (rst)            frozen_q <= 1'b1;
        else if (pwr_lost)  frozen_q <= 1'b1;
        else if (any_write) frozen_q <= 1'b0;
    end

    assign frozen  = frozen_q;
    assign advance = sec_tick && !frozen_q && !any_write && !pwr_lost;
endmodule

// File: rtl/cal_wrap_counter.sv
module cal_wrap_counter
    import rtc_cal_pkg::*;
#(
    parameter logic [FIELD_W-1:0] FIRST = 8'h00,
    parameter logic [FIELD_W-1:0] LAST  = 8'h59,
    parameter logic [FIELD_W-1:0] MASK  = 8'h7F
) (
    input  logic               clk,
    input  logic               rst,
    input  field_wr_t          wr,
    input  logic               step,
    output logic [FIELD_W-1:0] q,
    output logic               carry
);
    logic [FIELD_W-1:0] q_r;
    logic               at_last;

    assign at_last = (q_r >= LAST);
    assign carry   = step && at_last;

    always_ff @(posedge clk) begin
        if (rst)          q_r <= FIRST;
        else if (wr.load) q_r <= wr.value & MASK;
        else if (step)    q_r <= at_last ? FIRST : bcd_next(q_r);
    end

    assign q = q_r;
endmodule

// File: rtl/cal_hour_unit.sv
module cal_hour_unit
    import rtc_cal_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               fmt_12h,
    input  field_wr_t          wr,
    input  logic               step,
    output logic [FIELD_W-1:0] q,
    output logic               day_carry
);
    logic [FIELD_W-1:0] q_r;
    logic [FIELD_W-1:0] nxt;
    logic               wrap_day;
    logic [FIELD_W-1:0] inc24;
    logic [FIELD_W-1:0] inc12;

    always_comb begin
        inc24    = bcd_next({2'b00, q_r[5:0]});
        inc12    = bcd_next({3'b000, q_r[4:0]});
        nxt      = q_r;
        wrap_day = 1'b0;
        if (!fmt_12h) begin
            if (q_r[5:0] >= 6'h23) begin
                nxt      = 8'h00;
                wrap_day = 1'b1;
            end else begin
                nxt = inc24;
            end
        end else begin
            if (q_r[4:0] == 5'h12) begin
                nxt = {2'b00, q_r[PM_BIT], 5'h01};
            end else if (q_r[4:0] == 5'h11) begin
                nxt      = {2'b00, ~q_r[PM_BIT], 5'h12};
                wrap_day = q_r[PM_BIT];
            end else begin
                nxt = {2'b00, q_r[PM_BIT], inc12[4:0]};
            end
        end
    end

    assign day_carry = step && wrap_day;

    always_ff @(posedge clk) begin
        if (rst)          q_r <= 8'h00;
        else if (wr.load) q_r <= wr.value & MASK_HOUR;
        else if (step)    q_r <= nxt;
    end

    assign q = q_r;
endmodule

// File: rtl/cal_date_unit.sv
module cal_date_unit
    import rtc_cal_pkg::*;
#(
    parameter int DOW_DAYS = 7
) (
    input  logic               clk,
    input  logic               rst,
    input  field_wr_t          wr_date,
    input  field_wr_t          wr_month,
    input  field_wr_t          wr_year,
    input  field_wr_t          wr_dow,
    input  logic               step,
    output logic [FIELD_W-1:0] date_q,
    output logic [FIELD_W-1:0] month_q,
    output logic [FIELD_W-1:0] year_q,
    output logic [FIELD_W-1:0] dow_q
);
    localparam logic [FIELD_W-1:0] DOW_LAST = FIELD_W'(DOW_DAYS - 1);

    logic [FIELD_W-1:0] date_r, month_r, year_r, dow_r;
    logic               month_end, year_end;

    assign month_end = (date_r >= last_day(month_r, year_r));
    assign year_end  = (month_r >= 8'h12);

    always_ff @(posedge clk) begin
        if (rst) begin
            date_r  <= 8'h01;
            month_r <= 8'h01;
            year_r  <= 8'h00;
            dow_r   <= 8'h00;
        end else begin
            if (wr_date.load)     date_r <= wr_date.value & MASK_DATE;
            else if (step)        date_r <= month_end ? 8'h01 : bcd_next(date_r);

            if (wr_month.load)            month_r <= wr_month.value & MASK_MONTH;
            else if (step && month_end)   month_r <= year_end ? 8'h01 : bcd_next(month_r);

            if (wr_year.load)                        year_r <= wr_year.value & MASK_YEAR;
            else if (step && month_end && year_end)  year_r <= (year_r >= 8'h99) ? 8'h00 : bcd_next(year_r);

            if (wr_dow.load)      dow_r <= wr_dow.value & MASK_DOW;
            else if (step)        dow_r <= (dow_r >= DOW_LAST) ? 8'h00 : dow_r + 8'h01;
        end
    end

    assign date_q  = date_r;
    assign month_q = month_r;
    assign year_q  = year_r;
    assign dow_q   = dow_r;
endmodule

// File: rtl/bcd_calendar_counter.sv
module bcd_calendar_counter
    import rtc_cal_pkg::*;
#(
    parameter int DOW_DAYS = 7
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sec_tick,
    input  logic                 fmt_12h,
    input  logic                 pwr_lost,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [FIELD_W-1:0]   wr_data,
    output logic [FIELD_W-1:0]   rd_sec,
    output logic [FIELD_W-1:0]   rd_min,
    output logic [FIELD_W-1:0]   rd_hour,
    output logic [FIELD_W-1:0]   rd_date,
    output logic [FIELD_W-1:0]   rd_month,
    output logic [FIELD_W-1:0]   rd_year,
    output logic [FIELD_W-1:0]   rd_dow
);
    localparam int N_SM = 2;   // seconds and minutes share one counter type

    field_wr_t          wr_field [F_NONE];
    logic               frozen;
    logic               advance;
    logic               any_write;
    logic [N_SM:0]      sm_step;
    logic [FIELD_W-1:0] sm_q [N_SM];
    logic               day_step;

    assign any_write = wr_en && (field_e'(wr_addr) != F_NONE);

    generate
        for (genvar f = 0; f < int'(F_NONE); f++) begin : g_dec
            assign wr_field[f].load  = wr_en && (wr_addr == ADDR_W'(f));
            assign wr_field[f].value = wr_data;
        end
    endgenerate

    cal_hold_ctl u_hold (
        .clk       (clk),
        .rst       (rst),
        .sec_tick  (sec_tick),
        .pwr_lost  (pwr_lost),
        .any_write (any_write),
        .frozen    (frozen),
        .advance   (advance)
    );

    assign sm_step[0] = advance;

    generate
        for (genvar g = 0; g < N_SM; g++) begin : g_sm
            cal_wrap_counter #(
                .FIRST (8'h00),
                .LAST  (8'h59),
                .MASK  (MASK_SEC)
            ) u_cnt (
                .clk   (clk),
                .rst   (rst),
                .wr    (wr_field[g]),
                .step  (sm_step[g]),
                .q     (sm_q[g]),
                .carry (sm_step[g+1])
            );
        end
    endgenerate

    cal_hour_unit u_hour (
        .clk       (clk),
        .rst       (rst),
        .fmt_12h   (fmt_12h),
        .wr        (wr_field[F_HOUR]),
        .step      (sm_step[N_SM]),
        .q         (rd_hour),
        .day_carry (day_step)
    );

    cal_date_unit #(.DOW_DAYS(DOW_DAYS)) u_date (
        .clk      (clk),
        .rst      (rst),
        .wr_date  (wr_field[F_DATE]),
        .wr_month (wr_field[F_MONTH]),
        .wr_year  (wr_field[F_YEAR]),
        .wr_dow   (wr_field[F_DOW]),
        .step     (day_step),
        .date_q   (rd_date),
        .month_q  (rd_month),
        .year_q   (rd_year),
        .dow_q    (rd_dow)
    );

    assign rd_sec = sm_q[0];
    assign rd_min = sm_q[1];
endmodule

// File: rtl/cal_counter_checker.sv
module cal_counter_checker (
    input logic       clk,
    input logic       rst,
    input logic       fmt_12h,
    input logic       pwr_lost,
    input logic       wr_en,
    input logic [2:0] wr_addr,
    input logic [7:0] wr_data,
    input logic       frozen,
    input logic [7:0] rd_sec,
    input logic [7:0] rd_min,
    input logic [7:0] rd_hour,
    input logic [7:0] rd_date,
    input logic [7:0] rd_dow
);
    p_sec_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == 3'd0) |=> (rd_sec == ($past(wr_data) & 8'h7F)));

    p_write_blocks_count_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr != 3'd0 && wr_addr != 3'd7) |=> $stable(rd_sec));

    p_min_moves_on_wrap_r4: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> (rd_min == $past(rd_min)) || ($past(rd_sec) == 8'h59));

    p_pm_toggle_r6: assert property (@(posedge clk) disable iff (rst)
        (fmt_12h && !wr_en) |=> (rd_hour[5] == $past(rd_hour[5])) || ($past(rd_hour[4:0]) == 5'h11));

    p_dow_with_date_r10: assert property (@(posedge clk) disable iff (rst)
        (!wr_en) |=> (rd_date == $past(rd_date)) || (rd_dow != $past(rd_dow)));

    p_loss_freezes_r11: assert property (@(posedge clk) disable iff (rst)
        pwr_lost |=> frozen);

    p_frozen_holds_r11: assert property (@(posedge clk) disable iff (rst)
        (frozen && !wr_en) |=> $stable(rd_sec));
endmodule

bind bcd_calendar_counter cal_counter_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .fmt_12h  (fmt_12h),
    .pwr_lost (pwr_lost),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .frozen   (frozen),
    .rd_sec   (rd_sec),
    .rd_min   (rd_min),
    .rd_hour  (rd_hour),
    .rd_date  (rd_date),
    .rd_dow   (rd_dow)
);

// File: tb/tb_bcd_calendar_counter.sv
module tb_bcd_calendar_counter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sec_tick = 1'b0;
    logic       fmt_12h = 1'b0;
    logic       pwr_lost = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_sec, rd_min, rd_hour, rd_date, rd_month, rd_year, rd_dow;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #5 clk = ~clk;

    bcd_calendar_counter dut (
        .clk(clk), .rst(rst), .sec_tick(sec_tick), .fmt_12h(fmt_12h),
        .pwr_lost(pwr_lost), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_sec(rd_sec), .rd_min(rd_min), .rd_hour(rd_hour), .rd_date(rd_date),
        .rd_month(rd_month), .rd_year(rd_year), .rd_dow(rd_dow)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive on falling edge; the rising edge in between updates the design.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
    endtask

    task automatic set_all(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                           input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y,
                           input logic [7:0] w);
        wr(3'd2, h); wr(3'd1, m); wr(3'd0, s);
        wr(3'd3, d); wr(3'd4, mo); wr(3'd5, y); wr(3'd6, w);
    endtask

    task automatic t_reset();
        chk("R1", "sec", rd_sec, 8'h00);   chk("R1", "min", rd_min, 8'h00);
        chk("R1", "hour", rd_hour, 8'h00); chk("R1", "date", rd_date, 8'h01);
        chk("R1", "month", rd_month, 8'h01); chk("R1", "year", rd_year, 8'h00);
        chk("R1", "dow", rd_dow, 8'h00);
        tick(); tick();
        chk("R1", "frozen after reset sec", rd_sec, 8'h00);
    endtask

    task automatic t_write();
        wr(3'd0, 8'hFF);
        chk("R2", "sec mask", rd_sec, 8'h7F);
        wr(3'd2, 8'hFF);
        chk("R2", "hour mask", rd_hour, 8'h3F);
        wr(3'd6, 8'hFD);
        chk("R2", "dow mask", rd_dow, 8'h05);
        wr(3'd0, 8'h30);
        wr(3'd7, 8'h11);
        chk("R2", "addr7 sec", rd_sec, 8'h30);
        chk("R2", "addr7 dow", rd_dow, 8'h05);
        tick();
        chk("R2", "counting after write", rd_sec, 8'h31);
    endtask

    task automatic t_priority();
        wr(3'd0, 8'h10);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h20; sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
        chk("R3", "write wins sec", rd_sec, 8'h20);
        wr(3'd1, 8'h05); wr(3'd0, 8'h59);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'd1; wr_data = 8'h07; sec_tick = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; sec_tick = 1'b0;
        chk("R3", "tick dropped sec", rd_sec, 8'h59);
        chk("R3", "tick dropped min", rd_min, 8'h07);
    endtask

    task automatic t_sec_min();
        fmt_12h = 1'b0;
        set_all(8'h04, 8'h12, 8'h59, 8'h10, 8'h03, 8'h21, 8'h02);
        tick();
        chk("R4", "sec wrap", rd_sec, 8'h00);
        chk("R4", "min carry", rd_min, 8'h13);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick();
        chk("R4", "min wrap", rd_min, 8'h00);
        chk("R4", "hour carry", rd_hour, 8'h05);
        wr(3'd0, 8'h09);
        tick();
        chk("R4", "bcd digit", rd_sec, 8'h10);
    endtask

    task automatic t_24h();
        fmt_12h = 1'b0;
        set_all(8'h09, 8'h59, 8'h59, 8'h10, 8'h03, 8'h21, 8'h02);
        tick();
        chk("R5", "09->10", rd_hour, 8'h10);
        set_all(8'h23, 8'h59, 8'h59, 8'h10, 8'h03, 8'h21, 8'h02);
        tick();
        chk("R5", "23->00", rd_hour, 8'h00);
        chk("R5", "day carry", rd_date, 8'h11);
    endtask

    task automatic t_12h();
        fmt_12h = 1'b1;
        set_all(8'h11, 8'h59, 8'h59, 8'h05, 8'h06, 8'h21, 8'h01);
        tick();
        chk("R6", "11AM->12PM", rd_hour, 8'h32);
        chk("R6", "no day at noon", rd_date, 8'h05);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick();
        chk("R6", "12PM->01PM", rd_hour, 8'h21);
        set_all(8'h31, 8'h59, 8'h59, 8'h05, 8'h06, 8'h21, 8'h01);
        tick();
        chk("R6", "11PM->12AM", rd_hour, 8'h12);
        chk("R6", "day at midnight", rd_date, 8'h06);
        wr(3'd1, 8'h59); wr(3'd0, 8'h59);
        tick();
        chk("R6", "12AM->01AM", rd_hour, 8'h01);
        fmt_12h = 1'b0;
    endtask

    task automatic t_months();
        set_all(8'h23, 8'h59, 8'h59, 8'h30, 8'h04, 8'h21, 8'h00);
        tick();
        chk("R7", "Apr30 date", rd_date, 8'h01);
        chk("R7", "Apr30 month", rd_month, 8'h05);
        set_all(8'h23, 8'h59, 8'h59, 8'h30, 8'h11, 8'h21, 8'h00);
        tick();
        chk("R7", "Nov30 month", rd_month, 8'h12);
        set_all(8'h23, 8'h59, 8'h59, 8'h30, 8'h01, 8'h21, 8'h00);
        tick();
        chk("R7", "Jan30->31", rd_date, 8'h31);
        set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h08, 8'h21, 8'h00);
        tick();
        chk("R7", "Aug31 month", rd_month, 8'h09);
    endtask

    task automatic t_feb(input logic [7:0] y, input logic [7:0] exp_date, input logic [7:0] exp_month);
        set_all(8'h23, 8'h59, 8'h59, 8'h28, 8'h02, y, 8'h03);
        tick();
        chk("R8", $sformatf("Feb28 date y%h", y), rd_date, exp_date);
        chk("R8", $sformatf("Feb28 month y%h", y), rd_month, exp_month);
    endtask

    task automatic t_leap();
        t_feb(8'h24, 8'h29, 8'h02);
        t_feb(8'h23, 8'h01, 8'h03);
        t_feb(8'h00, 8'h29, 8'h02);
        t_feb(8'h10, 8'h01, 8'h03);
        t_feb(8'h12, 8'h29, 8'h02);
        set_all(8'h23, 8'h59, 8'h59, 8'h29, 8'h02, 8'h12, 8'h03);
        tick();
        chk("R8", "Feb29 leap rolls", rd_month, 8'h03);
        chk("R8", "Feb29 leap date", rd_date, 8'h01);
    endtask

    task automatic t_year();
        set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h41, 8'h02);
        tick();
        chk("R9", "year inc", rd_year, 8'h42);
        chk("R9", "month 01", rd_month, 8'h01);
        set_all(8'h23, 8'h59, 8'h59, 8'h31, 8'h12, 8'h99, 8'h06);
        tick();
        chk("R9", "sec", rd_sec, 8'h00);   chk("R9", "min", rd_min, 8'h00);
        chk("R9", "hour", rd_hour, 8'h00); chk("R9", "date", rd_date, 8'h01);
        chk("R9", "month", rd_month, 8'h01);
        chk("R9", "year wrap", rd_year, 8'h00);
        chk("R10", "dow wrap", rd_dow, 8'h00);
    endtask

    task automatic t_dow();
        set_all(8'h23, 8'h59, 8'h59, 8'h15, 8'h05, 8'h21, 8'h03);
        tick();
        chk("R10", "dow inc", rd_dow, 8'h04);
        wr(3'd2, 8'h10);
        tick();
        chk("R10", "dow idle mid-day", rd_dow, 8'h04);
    endtask

    task automatic t_power();
        wr(3'd0, 8'h40);
        @(negedge clk); pwr_lost = 1'b1;
        @(negedge clk); pwr_lost = 1'b0;
        tick(); tick(); tick();
        chk("R11", "frozen sec", rd_sec, 8'h40);
        wr(3'd1, 8'h22);
        tick();
        chk("R11", "resumed sec", rd_sec, 8'h41);
        @(negedge clk);
        pwr_lost = 1'b1; wr_en = 1'b1; wr_addr = 3'd0; wr_data = 8'h50;
        @(negedge clk);
        pwr_lost = 1'b0; wr_en = 1'b0;
        tick();
        chk("R11", "loss beats write", rd_sec, 8'h50);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_write();
        t_priority();
        t_sec_min();
        t_24h();
        t_12h();
        t_months();
        t_leap();
        t_year();
        t_dow();
        t_power();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule